// File: doc/BRIEF.md
# Segment Lookaside Buffer Array

This block is a small, fully associative store of address-segment descriptors. Each slot holds two 64-bit words. The segment-tag word carries the effective segment number and a valid flag. The segment-attribute word carries a segment-size code, the virtual segment number, protection keys, a no-execute flag and a page-size code. A command port accepts one operation per clock:

- write of an indexed slot, which is checked against a set of rejection rules;
- indexed read-back of either word;
- associative search by effective address;
- invalidation, either of every slot except slot 0 or of the single slot that an address hits.

The associative compare is combinational and always driven from the operand. Each slot picks its own compare granularity from its size code, so 256 MB and 1 TB segments can share the array. State changes happen on the next clock edge. A rejected command raises an error flag one cycle later. An invalidation that clears a valid slot raises a translation-cache flush request one cycle later. For an invalidate-by-address, the command chooses whether that request is qualified as local or global.

Top module: `slb_array`

## Requirements
- R1: A synchronous active-low reset clears every slot to zero. After reset, every indexed read returns 0 with no error, every search misses, and the error and flush outputs are low.
- R2: Command 1 (write) stores `{op_a[63:12], 12'b0}` as the tag word and `op_b` as the attribute word in slot `op_a[11:0]`. Command 2 reads back the tag word and command 3 reads back the attribute word of slot `op_a[11:0]` on `rd_data` in the same cycle.
- R3: A slot hits a 256 MB search when its tag word equals `{addr[63:28], 1'b1, 27'b0}` and its size code `attr[63:62]` is 00. Tag bit 27 is the valid flag.
- R4: A slot hits a 1 TB search when its tag word equals `{addr[63:40], 12'b0, 1'b1, 27'b0}` and its size code is 01. A slot whose tag matches at 256 MB granularity but whose size code is 01 does not hit.
- R5: When several slots hit, the lowest-numbered one supplies `lk_vsid` and `lk_psz`.
- R6: A write is rejected, with `cmd_err` high in the next cycle and no slot changed, in any of these cases: `op_a[11:0]` ≥ NUM_ENT; any of `op_a[26:12]` is set; the size code is 10 or 11; or the size code is 01 while SUPPORT_1T is 0.
- R7: The page-size code is `{op_b[8], op_b[5:4]}`. A write whose code is not in the configured list (default: index 0 = 000, index 1 = 100, index 2 = 101) is rejected. On an accepted write, the list index is stored with the slot and appears on `lk_psz` when that slot hits.
- R8: Command 4 clears the valid flag of every slot except slot 0. It pulses `flush_req` with `flush_glb` low in the next cycle only if at least one slot from 1 upward was valid.
- R9: Commands 5 (local) and 6 (global) clear the valid flag of the slot that `op_a` hits. They pulse `flush_req` in the next cycle, with `flush_glb` set only for command 6. On a miss, nothing changes and no flush is raised.
- R10: Command 7 returns the hitting slot's attribute word on `rd_data`, or all ones on a miss. When `mode32` is high, `op_a[63:32]` is treated as zero for that search.
- R11: Commands 2 and 3 with `op_a[11:0]` ≥ NUM_ENT return 0 and raise `cmd_err` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd | input | 3 | Command: 0 idle, 1 write, 2 read tag, 3 read attribute, 4 invalidate all, 5 invalidate by address (local), 6 invalidate by address (global), 7 find |
| op_a | input | 64 | Address operand, or tag word and slot number |
| op_b | input | 64 | Attribute word for writes |
| mode32 | input | 1 | Clears the upper 32 address bits for a find |
| lk_hit | output | 1 | Search hit |
| lk_vsid | output | 64 | Attribute word of the winning slot, all ones on a miss |
| lk_psz | output | PSZ_W (2) | Page-size list index of the winning slot, 0 on a miss |
| rd_data | output | 64 | Read or find result |
| cmd_err | output | 1 | Registered: the previous command was rejected |
| flush_req | output | 1 | Registered: the previous invalidation cleared a valid slot |
| flush_glb | output | 1 | Registered: that flush request is global |

## Verification
The hardest situation to reach from the ports is one where the winning slot changes because an invalidation removed a lower-numbered duplicate. The stimulus loads the same segment into slots 2 and 7 with different attribute words. A search must return slot 2's word. After an invalidate-by-address, the same search must return slot 7's word, and the next invalidation must clear slot 7 and raise a global flush. The 1 TB-support switch is exercised by a second instance that has the feature disabled and shares the same inputs. Only that instance's error flag is compared, and it must reject exactly the writes that carry size code 01.

// File: rtl/slb_pkg.sv
// Package: shared command encoding and word field positions for the
// segment lookaside buffer. Assumes 64-bit tag and attribute words.
package slb_pkg;
    typedef enum logic [2:0] {
        CMD_IDLE  = 3'd0,
        CMD_WRITE = 3'd1,
        CMD_RDTAG = 3'd2,
        CMD_RDATR = 3'd3,
        CMD_INVAL = 3'd4,
        CMD_INVLO = 3'd5,
        CMD_INVGL = 3'd6,
        CMD_FIND  = 3'd7
    } slb_cmd_e;

    localparam int WORD_W    = 64;
    localparam int VALID_BIT = 27;
    localparam int SEG256_LO = 28;
    localparam int SEG1T_LO  = 40;
    localparam int SLOT_W    = 12;
    localparam int PCODE_W   = 3;

    localparam logic [1:0] SZ_256M = 2'b00;
    localparam logic [1:0] SZ_1T   = 2'b01;
endpackage

// File: rtl/slb_prio.sv
// Lowest-index-first priority encoder.
// Assumes N >= 1; idx is 0 when no bit is set.
module slb_prio #(
    parameter int N = 32,
    parameter int W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0] vec,
    output logic         any,
    output logic [W-1:0] idx
);
    // Scan downward so that the lowest set bit is the last assignment.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = W'(i);
        end
    end

    // Flag any request present.
    assign any = |vec;
endmodule

// File: rtl/slb_match.sv
// Per-slot associative compare. Each slot compares its tag word with
// the key of its own granularity, selected by its size code.
// Assumes the keys already carry the valid flag set.
module slb_match
    import slb_pkg::*;
#(
    parameter int NUM_ENT = 32
) (
    input  logic [NUM_ENT-1:0][WORD_W-1:0] tag_q,
    input  logic [NUM_ENT-1:0][1:0]        size_q,
    input  logic [WORD_W-1:0]              key256,
    input  logic [WORD_W-1:0]              key1t,
    output logic [NUM_ENT-1:0]             hit_vec
);
    for (genvar g = 0; g < NUM_ENT; g++) begin : g_slot
        // One comparator pair per slot; the size code gates each side.
        assign hit_vec[g] = ((tag_q[g] == key256) && (size_q[g] == SZ_256M)) ||
                            ((tag_q[g] == key1t)  && (size_q[g] == SZ_1T));
    end
endmodule

// File: rtl/slb_wcheck.sv
// Write validation: slot range, reserved tag bits, size code, 1 TB
// support, and page-size code lookup in the configured list.
// Assumes the list packs entry k in bits [3k+2:3k].
module slb_wcheck
    import slb_pkg::*;
#(
    parameter int                       NUM_ENT    = 32,
    parameter int                       NUM_PSZ    = 3,
    parameter logic [NUM_PSZ*3-1:0]     PSZ_CODES  = 9'b101_100_000,
    parameter bit                       SUPPORT_1T = 1'b1,
    parameter int                       PSZ_W      = (NUM_PSZ > 1) ? $clog2(NUM_PSZ) : 1
) (
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    output logic              accept,
    output logic [PSZ_W-1:0]  psz_idx
);
    logic                 slot_ok;
    logic                 rsv_ok;
    logic                 size_ok;
    logic [1:0]           size_code;
    logic [PCODE_W-1:0]   pcode;
    logic [NUM_PSZ-1:0]   pmatch;
    logic                 pcode_ok;

    // Slot range and reserved-bit tests on the tag operand.
    assign slot_ok   = ({20'd0, op_a[SLOT_W-1:0]} < NUM_ENT);
    assign rsv_ok    = (op_a[VALID_BIT-1:SLOT_W] == '0);

    // Size code must be a legal granularity the instance supports.
    assign size_code = op_b[63:62];
    assign size_ok   = (size_code == SZ_256M) ||
                       ((size_code == SZ_1T) && SUPPORT_1T);

    // Page-size code compared against every configured list entry.
    assign pcode = {op_b[8], op_b[5:4]};
    for (genvar k = 0; k < NUM_PSZ; k++) begin : g_psz
        assign pmatch[k] = (pcode == PSZ_CODES[k*3 +: 3]);
    end

    slb_prio #(.N(NUM_PSZ), .W(PSZ_W)) u_psz_prio (
        .vec (pmatch),
        .any (pcode_ok),
        .idx (psz_idx)
    );

    // Overall verdict.
    assign accept = slot_ok && rsv_ok && size_ok && pcode_ok;
endmodule

// File: rtl/slb_array.sv
// Segment lookaside buffer: fully associative slot array with an indexed
// write/read port, combinational search, and invalidation.
// Assumes NUM_ENT >= 2 and NUM_ENT <= 4096; one command per cycle.
module slb_array
    import slb_pkg::*;
#(
    parameter int                   NUM_ENT    = 32,
    parameter int                   NUM_PSZ    = 3,
    parameter logic [NUM_PSZ*3-1:0] PSZ_CODES  = 9'b101_100_000,
    parameter bit                   SUPPORT_1T = 1'b1,
    parameter int                   PSZ_W      = (NUM_PSZ > 1) ? $clog2(NUM_PSZ) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cmd,
    input  logic [63:0]       op_a,
    input  logic [63:0]       op_b,
    input  logic              mode32,
    output logic              lk_hit,
    output logic [63:0]       lk_vsid,
    output logic [PSZ_W-1:0]  lk_psz,
    output logic [63:0]       rd_data,
    output logic              cmd_err,
    output logic              flush_req,
    output logic              flush_glb
);
    localparam int IDX_W = $clog2(NUM_ENT);

    slb_cmd_e                          c;
    logic [NUM_ENT-1:0][WORD_W-1:0]    tag_q;
    logic [NUM_ENT-1:0][WORD_W-1:0]    atr_q;
    logic [NUM_ENT-1:0][PSZ_W-1:0]     psz_q;
    logic [NUM_ENT-1:0][1:0]           size_q;
    logic [NUM_ENT-1:0]                hit_vec;
    logic [WORD_W-1:0]                 srch_addr;
    logic [WORD_W-1:0]                 key256;
    logic [WORD_W-1:0]                 key1t;
    logic                              hit_any;
    logic [IDX_W-1:0]                  hit_idx;
    logic                              slot_ok;
    logic [IDX_W-1:0]                  slot_idx;
    logic                              wr_ok;
    logic [PSZ_W-1:0]                  wr_psz;
    logic                              upper_valid;

    assign c = slb_cmd_e'(cmd);

    // Search address: find in 32-bit mode ignores the upper half.
    assign srch_addr = ((c == CMD_FIND) && mode32) ? {32'd0, op_a[31:0]} : op_a;

    // Keys at both granularities, valid flag set.
    assign key256 = {srch_addr[63:SEG256_LO], 1'b1, 27'd0};
    assign key1t  = {srch_addr[63:SEG1T_LO], 12'd0, 1'b1, 27'd0};

    // Size code of every slot for the comparators.
    for (genvar g = 0; g < NUM_ENT; g++) begin : g_size
        assign size_q[g] = atr_q[g][63:62];
    end

    slb_match #(.NUM_ENT(NUM_ENT)) u_match (
        .tag_q   (tag_q),
        .size_q  (size_q),
        .key256  (key256),
        .key1t   (key1t),
        .hit_vec (hit_vec)
    );

    slb_prio #(.N(NUM_ENT), .W(IDX_W)) u_hit_prio (
        .vec (hit_vec),
        .any (hit_any),
        .idx (hit_idx)
    );

    slb_wcheck #(
        .NUM_ENT    (NUM_ENT),
        .NUM_PSZ    (NUM_PSZ),
        .PSZ_CODES  (PSZ_CODES),
        .SUPPORT_1T (SUPPORT_1T),
        .PSZ_W      (PSZ_W)
    ) u_wcheck (
        .op_a    (op_a),
        .op_b    (op_b),
        .accept  (wr_ok),
        .psz_idx (wr_psz)
    );

    // Search results of the winning slot.
    assign lk_hit  = hit_any;
    assign lk_vsid = hit_any ? atr_q[hit_idx] : '1;
    assign lk_psz  = hit_any ? psz_q[hit_idx] : '0;

    // Indexed slot decode for reads and writes.
    assign slot_ok  = ({20'd0, op_a[SLOT_W-1:0]} < NUM_ENT);
    assign slot_idx = op_a[IDX_W-1:0];

    // Read-side result mux.
    always_comb begin
        rd_data = '0;
        case (c)
            CMD_RDTAG: rd_data = slot_ok ? tag_q[slot_idx] : '0;
            CMD_RDATR: rd_data = slot_ok ? atr_q[slot_idx] : '0;
            CMD_FIND:  rd_data = lk_vsid;
            default:   rd_data = '0;
        endcase
    end

    // Any valid slot that invalidate-all would clear.
    always_comb begin
        upper_valid = 1'b0;
        for (int i = 1; i < NUM_ENT; i++) begin
            upper_valid = upper_valid | tag_q[i][VALID_BIT];
        end
    end

    // Slot array update: writes and invalidations.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q <= '0;
            atr_q <= '0;
            psz_q <= '0;
        end else begin
            case (c)
                CMD_WRITE: begin
                    if (wr_ok) begin
                        tag_q[slot_idx] <= {op_a[63:SLOT_W], {SLOT_W{1'b0}}};
                        atr_q[slot_idx] <= op_b;
                        psz_q[slot_idx] <= wr_psz;
                    end
                end
                CMD_INVAL: begin
                    for (int i = 1; i < NUM_ENT; i++) begin
                        tag_q[i][VALID_BIT] <= 1'b0;
                    end
                end
                CMD_INVLO, CMD_INVGL: begin
                    if (hit_any) tag_q[hit_idx][VALID_BIT] <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    // Registered error and flush indications for the previous command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_err   <= 1'b0;
            flush_req <= 1'b0;
            flush_glb <= 1'b0;
        end else begin
            cmd_err   <= ((c == CMD_WRITE) && !wr_ok) ||
                         (((c == CMD_RDTAG) || (c == CMD_RDATR)) && !slot_ok);
            flush_req <= ((c == CMD_INVAL) && upper_valid) ||
                         (((c == CMD_INVLO) || (c == CMD_INVGL)) && hit_any);
            flush_glb <= (c == CMD_INVGL) && hit_any;
        end
    end
endmodule

// File: rtl/slb_array_chk.sv
// Checker for slb_array: temporal relations between the command port
// and the registered error and flush outputs. Bound to every instance.
module slb_array_chk #(
    parameter int NUM_ENT = 32,
    parameter int PSZ_W   = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       cmd,
    input logic [63:0]      op_a,
    input logic             lk_hit,
    input logic [PSZ_W-1:0] lk_psz,
    input logic [63:0]      rd_data,
    input logic             cmd_err,
    input logic             flush_req,
    input logic             flush_glb
);
    // R9: a global qualifier never appears without a request
    a_r9_glb_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        flush_glb |-> flush_req);

    // R8: invalidate-all only ever raises a local request
    a_r8_inval_local: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cmd) == 3'd4) |-> !flush_glb);

    // R8, R9: flush requests only follow invalidation commands
    a_r9_flush_source: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |-> ($past(cmd) == 3'd4 || $past(cmd) == 3'd5 || $past(cmd) == 3'd6));

    // R6, R11: errors only follow writes or indexed reads
    a_r6_err_source: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> ($past(cmd) == 3'd1 || $past(cmd) == 3'd2 || $past(cmd) == 3'd3));

    // R11: an out-of-range indexed read is flagged next cycle
    a_r11_read_range: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd == 3'd2 || cmd == 3'd3) && ({20'd0, op_a[11:0]} >= NUM_ENT)) |=> cmd_err);

    // R10: a find that misses returns all ones
    a_r10_find_miss: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd == 3'd7) && !lk_hit) |-> (rd_data == 64'hFFFF_FFFF_FFFF_FFFF));

    // R7: no page-size index without a hit
    a_r7_psz_miss: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_psz == '0));
endmodule

bind slb_array slb_array_chk #(.NUM_ENT(NUM_ENT), .PSZ_W(PSZ_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd       (cmd),
    .op_a      (op_a),
    .lk_hit    (lk_hit),
    .lk_psz    (lk_psz),
    .rd_data   (rd_data),
    .cmd_err   (cmd_err),
    .flush_req (flush_req),
    .flush_glb (flush_glb)
);

// File: tb/slb_array_tb.sv
// Scoreboard bench: the driver issues one command per cycle and queues
// its expectations; the monitor compares them at the falling edge.
module slb_array_tb;
    localparam time CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cmd = 3'd0;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic        mode32 = 1'b0;
    logic        lk_hit, cmd_err, flush_req, flush_glb;
    logic [63:0] lk_vsid, rd_data;
    logic [1:0]  lk_psz;
    logic        n_hit, n_err, n_fr, n_fg;
    logic [63:0] n_vsid, n_rd;
    logic [1:0]  n_psz;

    int n_chk = 0;
    int n_fail = 0;

    typedef struct {
        string       tag;
        bit          chk_rd;
        logic [63:0] rd;
        bit          chk_lk;
        bit          hit;
        logic [1:0]  psz;
        bit          err;
        bit          errn;
        bit          fl;
        bit          glb;
    } item_t;

    item_t q[$];

    always #(CLK_P/2) clk = ~clk;

    slb_array u_dut (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .op_a(op_a), .op_b(op_b),
        .mode32(mode32), .lk_hit(lk_hit), .lk_vsid(lk_vsid), .lk_psz(lk_psz),
        .rd_data(rd_data), .cmd_err(cmd_err), .flush_req(flush_req),
        .flush_glb(flush_glb)
    );

    slb_array #(.SUPPORT_1T(1'b0)) u_dut_n1t (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .op_a(op_a), .op_b(op_b),
        .mode32(mode32), .lk_hit(n_hit), .lk_vsid(n_vsid), .lk_psz(n_psz),
        .rd_data(n_rd), .cmd_err(n_err), .flush_req(n_fr),
        .flush_glb(n_fg)
    );

    function automatic logic [63:0] tag256(input logic [63:0] a);
        return {a[63:28], 1'b1, 27'd0};
    endfunction

    function automatic logic [63:0] tag1t(input logic [63:0] a);
        return {a[63:40], 12'd0, 1'b1, 27'd0};
    endfunction

    function automatic logic [63:0] atr(input logic [1:0] sz, input logic [49:0] vid,
                                        input logic [2:0] pc);
        return {sz, vid, 3'b000, pc[2], 2'b00, pc[1:0], 4'b0000};
    endfunction

    function automatic item_t mk(input string tag, input bit chk_rd, input logic [63:0] rd,
                                 input bit chk_lk, input bit hit, input logic [1:0] psz,
                                 input bit err, input bit errn, input bit fl, input bit glb);
        item_t it;
        it.tag = tag; it.chk_rd = chk_rd; it.rd = rd; it.chk_lk = chk_lk;
        it.hit = hit; it.psz = psz; it.err = err; it.errn = errn;
        it.fl = fl; it.glb = glb;
        return it;
    endfunction

    task automatic cmp(input string tag, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] c, input logic [63:0] a, input logic [63:0] b,
                         input logic m32, input item_t it);
        @(posedge clk);
        #1;
        cmd = c; op_a = a; op_b = b; mode32 = m32;
        q.push_back(it);
    endtask

    task automatic idle(input string tag);
        issue(3'd0, '0, '0, 1'b0, mk(tag, 0, '0, 0, 0, 2'd0, 0, 0, 0, 0));
    endtask

    // Monitor: compares the current command's combinational results and
    // the previous command's registered results.
    initial begin
        item_t prev;
        item_t it;
        prev = mk("reset", 0, '0, 0, 0, 2'd0, 0, 0, 0, 0);
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                it = q.pop_front();
                if (it.chk_rd) cmp(it.tag, "rd_data", rd_data, it.rd);
                if (it.chk_lk) begin
                    cmp(it.tag, "lk_hit", {63'd0, lk_hit}, {63'd0, it.hit});
                    cmp(it.tag, "lk_psz", {62'd0, lk_psz}, {62'd0, it.psz});
                end
                cmp(prev.tag, "cmd_err", {63'd0, cmd_err}, {63'd0, prev.err});
                cmp(prev.tag, "no1t cmd_err", {63'd0, n_err}, {63'd0, prev.errn});
                cmp(prev.tag, "flush_req", {63'd0, flush_req}, {63'd0, prev.fl});
                cmp(prev.tag, "flush_glb", {63'd0, flush_glb}, {63'd0, prev.glb});
                prev = it;
            end
        end
    end

    initial begin
        #(CLK_P * 200000);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] aA, aB, aC, aD, aF, ones;
        logic [63:0] v1, v2, v3, v5, v6, v9, vD;
        aA = 64'h1234_5678_9ABC_DEF0;
        aB = 64'hABCD_EF12_3456_7890;
        aC = 64'h1111_1111_2000_0000;
        aD = 64'h7777_0000_0000_0000;
        aF = 64'h0F0F_0F0F_0F0F_0F0F;
        ones = '1;
        v1 = atr(2'b00, 50'h1111, 3'b100);
        v2 = atr(2'b01, 50'h2222, 3'b000);
        v3 = atr(2'b00, 50'h3333, 3'b000);
        v5 = atr(2'b01, 50'h5555, 3'b000);
        v6 = atr(2'b00, 50'h6666, 3'b101);
        v9 = atr(2'b00, 50'h9999, 3'b000);
        vD = atr(2'b00, 50'h7777, 3'b000);

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: empty after reset
        issue(3'd2, 64'd3, '0, 0, mk("R1 read tag", 1, '0, 0, 0, 2'd0, 0, 0, 0, 0));
        issue(3'd3, 64'd31, '0, 0, mk("R1 read attr", 1, '0, 0, 0, 2'd0, 0, 0, 0, 0));
        issue(3'd7, aA, '0, 0, mk("R1 find", 1, ones, 1, 0, 2'd0, 0, 0, 0, 0));

        // R2, R3, R7: write 256 MB slot 2 and read it back
        issue(3'd1, tag256(aA) | 64'd2, v1, 0, mk("R2 write", 0, '0, 0, 0, 2'd0, 0, 0, 0, 0));
        issue(3'd2, tag256(aA) | 64'd2, '0, 0, mk("R2 read tag", 1, tag256(aA), 0, 0, 2'd0, 0, 0, 0, 0));
        issue(3'd3, 64'd2, '0, 0, mk("R2 read attr", 1, v1, 0, 0, 2'd0, 0, 0, 0, 0));
        issue(3'd7, {aA[63:28], 28'h0ABCDEF}, '0, 0, mk("R3 find 256M", 1, v1, 1, 1, 2'd1, 0, 0, 0, 0));

        // R4: 1 TB slot 1; 256M-shaped tag with 1 TB size in slot 5
        issue(3'd1, tag1t(aB) | 64'd1, v2, 0, mk("R4 write 1T", 0, '0, 0, 0, 2'd0, 0, 1, 0, 0));
        issue(3'd7, aB, '0, 0, mk("R4 find 1T", 1, v2, 1, 1, 2'd0, 0, 0, 0, 0));
        issue(3'd1, tag256(aC) | 64'd5, v5, 0, mk("R4 write mis-sized", 0, '0, 0, 0, 2'd0, 0, 1, 0, 0));
        issue(3'd7, aC, '0, 0, mk("R4 size blocks match", 1, ones, 1, 0, 2'd0, 0, 0, 0, 0));

        // R5: duplicate in slot 7, slot 2 must win
        issue(3'd1, tag256(aA) | 64'd7, v3, 0, mk("R5 write dup", 0, '0, 0, 0, 2'd0, 0, 0, 0, 0));
        issue(3'd7, aA, '0, 0, mk("R5 lowest wins", 1, v1, 1, 1, 2'd1, 0, 0, 0, 0));

        // R6, R11: rejected writes and out-of-range read
        issue(3'd1, tag256(aA) | 64'd32, v3, 0, mk("R6 slot range", 0, '0, 0, 0, 2'd0, 1, 1, 0, 0));
        issue(3'd2, 64'd32, '0, 0, mk("R11 read range", 1, '0, 0, 0, 2'd0, 1, 1, 0, 0));
        issue(3'd1, tag256(aA) | 64'h1000 | 64'd3, v3, 0, mk("R6 reserved bit", 0, '0, 0, 0, 2'd0, 1, 1, 0, 0));
        issue(3'd2, 64'd3, '0, 0, mk("R6 slot untouched", 1, '0, 0, 0, 2'd0, 0, 0, 0, 0));
        issue(3'd1, tag256(aA) | 64'd3, atr(2'b10, 50'h4, 3'b000), 0, mk("R6 bad size", 0, '0, 0, 0, 2'd0, 1, 1, 0, 0));
        issue(3'd3, 64'd3, '0, 0, mk("R6 attr untouched", 1, '0, 0, 0, 2'd0, 0, 0, 0, 0));

        // R7: unlisted page code rejected; index 2 stored
        issue(3'd1, tag256(aA) | 64'd3, atr(2'b00, 50'h4, 3'b011), 0, mk("R7 bad page code", 0, '0, 0, 0, 2'd0, 1, 1, 0, 0));
        issue(3'd3, 64'd3, '0, 0, mk("R7 attr untouched", 1, '0, 0, 0, 2'd0, 0, 0, 0, 0));
        issue(3'd1, tag256(aF) | 64'd6, v6, 0, mk("R7 write idx2", 0, '0, 0, 0, 2'd0, 0, 0, 0, 0));
        issue(3'd7, aF, '0, 0, mk("R7 psz index", 1, v6, 1, 1, 2'd2, 0, 0, 0, 0));

        // R10: 32-bit mode search
        issue(3'd1, 64'h0000_0000_3800_0009, v9, 0, mk("R10 write", 0, '0, 0, 0, 2'd0, 0, 0, 0, 0));
        issue(3'd7, 64'hFFFF_FFFF_3000_1234, '0, 1, mk("R10 mode32 hit", 1, v9, 1, 1, 2'd0, 0, 0, 0, 0));
        issue(3'd7, 64'hFFFF_FFFF_3000_1234, '0, 0, mk("R10 full miss", 1, ones, 1, 0, 2'd0, 0, 0, 0, 0));

        // R9: invalidate by address, local then global then miss
        issue(3'd5, aA, '0, 0, mk("R9 inv local", 0, '0, 0, 0, 2'd0, 0, 0, 1, 0));
        issue(3'd7, aA, '0, 0, mk("R9 next slot wins", 1, v3, 1, 1, 2'd0, 0, 0, 0, 0));
        issue(3'd6, aA, '0, 0, mk("R9 inv global", 0, '0, 0, 0, 2'd0, 0, 0, 1, 1));
        issue(3'd7, aA, '0, 0, mk("R9 gone", 1, ones, 1, 0, 2'd0, 0, 0, 0, 0));
        issue(3'd5, aA, '0, 0, mk("R9 inv miss", 0, '0, 0, 0, 2'd0, 0, 0, 0, 0));

        // R8: invalidate all spares slot 0
        issue(3'd1, tag256(aD) | 64'd0, vD, 0, mk("R8 write slot0", 0, '0, 0, 0, 2'd0, 0, 0, 0, 0));
        issue(3'd4, '0, '0, 0, mk("R8 inv all", 0, '0, 0, 0, 2'd0, 0, 0, 1, 0));
        issue(3'd7, aD, '0, 0, mk("R8 slot0 kept", 1, vD, 1, 1, 2'd0, 0, 0, 0, 0));
        issue(3'd7, aB, '0, 0, mk("R8 slot1 cleared", 1, ones, 1, 0, 2'd0, 0, 0, 0, 0));
        issue(3'd2, 64'd1, '0, 0, mk("R8 valid bit clear", 1, tag1t(aB) & ~(64'd1 << 27), 0, 0, 2'd0, 0, 0, 0, 0));
        issue(3'd4, '0, '0, 0, mk("R8 inv all idle", 0, '0, 0, 0, 2'd0, 0, 0, 0, 0));
        issue(3'd2, 64'd0, '0, 0, mk("R8 slot0 tag", 1, tag256(aD), 0, 0, 2'd0, 0, 0, 0, 0));

        idle("tail");
        idle("tail");
        @(posedge clk);
        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule